// File: doc/BRIEF.md
# Synchronous Burst Pipelined Static RAM

This block is a clocked word memory for cache-style accesses. Each word is 64 bits wide and is split into eight byte lanes. The address and all control inputs are registered on the rising clock edge. A transfer starts when the processor-side address strobe or the controller-side address strobe is sampled low at a clock edge. Three chip selects decide whether that start selects the block. After the start, an advance input either steps a two-bit burst count or holds it. The burst order is either linear (the low address bits are incremented and wrap) or interleaved (the low address bits are XORed with the count). A static input picks the order.

A start from the processor strobe is always a read. A start from the controller strobe, and every cycle after a start, is a read or a write depending on the write inputs sampled on that edge. There are two write inputs: a global write that stores all lanes, and a byte-write enable used together with eight active-low lane enables. Lane enables are applied on the edge that takes the data, so a write may follow a read start on the same address.

Read data leaves through an output register, one clock after the access. A parameter selects flow-through timing instead. The output enable is not clocked. The drive-enable output stands in for the tristate control, and the data output reads zero whenever the drive enable is low.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is selected only if, on the start edge, sel_a_ni is 0, sel_b_i is 1 and sel_c_ni is 0. A controller-strobe start with any other select pattern stores nothing and ends the burst, so no data is driven afterwards.
- R2: While sel_a_ni is 1, a low cpu_strobe_ni is ignored. With ctl_strobe_ni high, that cycle behaves as a normal continue or suspend cycle of the current burst.
- R3: cpu_strobe_ni low with sel_a_ni low, but with sel_b_i low or sel_c_ni high, deselects the block. drive_o is 0 from the next cycle on, even in the middle of a burst. A controller-strobe start with bad selects does the same.
- R4: A start by the processor strobe with a valid select is a read of addr_i. The write inputs on that edge store nothing.
- R5: A start by ctl_strobe_ni low, while the processor strobe is not taken, loads addr_i. That cycle is a write if the write inputs request one on that edge, and a read otherwise.
- R6: With no start on an edge, adv_ni low moves to the next burst address and adv_ni high stays on the current address. This holds for reads and for writes.
- R7: The burst order affects only address bits [1:0]. With linear_i=1 they are start+count mod 4. With linear_i=0 they are start XOR count. The count is 0, 1, 2, 3 for the first to fourth access.
- R8: wr_all_ni low writes all eight lanes, whatever wr_en_ni and lane_ni are.
- R9: With wr_all_ni high and wr_en_ni low, lane n (lane_ni[n], n = 0..7) writes data bits 8n+7..8n, and only lanes with a low bit are written. wr_en_ni high, or lane_ni all ones, is a read.
- R10: drive_o is 1 only when a read result is ready and out_en_ni is 0. out_en_ni acts without a clock, and data_o is 0 whenever drive_o is 0.
- R11: With PIPELINED=1, data for a read registered at edge k is on data_o after edge k+1. Each read returns the last value written to that word.
- R12: Lane enables and data are taken on the edge of the write itself. A write cycle right after a processor-strobe read start stores into the address that start loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address for a start |
| cpu_strobe_ni | input | 1 | Processor address strobe, active low |
| ctl_strobe_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| sel_a_ni | input | 1 | Chip select, active low; gates the processor strobe |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| wr_all_ni | input | 1 | Global write of all lanes, active low |
| wr_en_ni | input | 1 | Byte-write enable, active low |
| lane_ni | input | LANES | Lane write enables, active low |
| out_en_ni | input | 1 | Output enable, active low, not clocked |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| wdata_i | input | 8*LANES | Write data |
| data_o | output | 8*LANES | Read data, zero while not driven |
| drive_o | output | 1 | Output driver enable |

## Verification
The bench first fills the whole array with linear controller-strobe write bursts. It then reads bursts that start at an odd low address in both orders, because the linear and interleaved sequences differ from the second access onward. Partial-lane writes use scattered lane masks, and each is read back. This separates lane-to-bit mapping faults from faults where a global write overrides the lanes or the lanes are ignored. Further cases check that each start source applies its own select rule:
- a processor start carrying write inputs,
- a controller start with the first select high,
- mid-burst deselects through each strobe.

Suspended writes and the output enable held high separate address hold from address advance, and the clocked output state from the unclocked gate.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W  = 8;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic load;
    logic desel;
    logic adv;
    logic wr;
    logic rd;
  } acc_ctl_t;
endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;

  function automatic logic [ADDR_W-1:0] seq_addr(logic [ADDR_W-1:0] base,
                                                 logic [BURST_W-1:0] cnt,
                                                 logic lin);
    logic [BURST_W-1:0] low;
    low = lin ? base[BURST_W-1:0] + cnt : base[BURST_W-1:0] ^ cnt;
    return {base[ADDR_W-1:BURST_W], low};
  endfunction

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = addr_i;
      cnt_d  = '0;
    end else if (adv_i) begin
      cnt_d  = cnt_q + BURST_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr_o = seq_addr(base_q, cnt_q, linear_i);
  assign nxt_addr_o = seq_addr(base_d, cnt_d, linear_i);
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_strobe_ni,
  input  logic             ctl_strobe_ni,
  input  logic             adv_ni,
  input  logic             sel_a_ni,
  input  logic             sel_b_i,
  input  logic             sel_c_ni,
  input  logic             wr_all_ni,
  input  logic             wr_en_ni,
  input  logic [LANES-1:0] lane_ni,
  output acc_ctl_t         ctl_o,
  output logic [LANES-1:0] mask_o
);
  logic active_q, active_d;
  logic cpu_start, ctl_start, start, sel_ok;

  always_comb begin
    // processor strobe only counts while the first select is low
    cpu_start = !cpu_strobe_ni && !sel_a_ni;
    ctl_start = !ctl_strobe_ni && !cpu_start;
    start     = cpu_start || ctl_start;
    sel_ok    = !sel_a_ni && sel_b_i && !sel_c_ni;

    if (!wr_all_ni)     mask_o = '1;
    else if (!wr_en_ni) mask_o = ~lane_ni;
    else                mask_o = '0;

    ctl_o.load  = start && sel_ok;
    ctl_o.desel = start && !sel_ok;
    ctl_o.adv   = !start && active_q && !adv_ni;

    active_d = ctl_o.load ? 1'b1 : (ctl_o.desel ? 1'b0 : active_q);
    ctl_o.wr = active_d && (|mask_o) && !cpu_start;
    ctl_o.rd = active_d && !ctl_o.wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end
endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cpu_strobe_ni,
  input  logic                    ctl_strobe_ni,
  input  logic                    adv_ni,
  input  logic                    sel_a_ni,
  input  logic                    sel_b_i,
  input  logic                    sel_c_ni,
  input  logic                    wr_all_ni,
  input  logic                    wr_en_ni,
  input  logic [LANES-1:0]        lane_ni,
  input  logic                    out_en_ni,
  input  logic                    linear_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    drive_o
);
  localparam int DATA_W = LANES * LANE_W;

  acc_ctl_t          ctl;
  logic [LANES-1:0]  mem_mask;
  logic              mem_we;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] rd_word, out_data;
  logic              rd_q, out_vld;

  sram_access_ctrl #(.LANES(LANES)) i_ctrl (
    .clk_i, .rst_ni, .cpu_strobe_ni, .ctl_strobe_ni, .adv_ni,
    .sel_a_ni, .sel_b_i, .sel_c_ni, .wr_all_ni, .wr_en_ni, .lane_ni,
    .ctl_o  (ctl),
    .mask_o (mem_mask)
  );

  sram_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk_i, .rst_ni,
    .load_i     (ctl.load),
    .adv_i      (ctl.adv),
    .linear_i,
    .addr_i,
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  assign mem_we = ctl.wr;

  sram_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES)) i_mem (
    .clk_i,
    .we_i    (mem_we),
    .mask_i  (mem_mask),
    .waddr_i (nxt_addr),
    .wdata_i,
    .raddr_i (cur_addr),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= ctl.rd;
  end

  if (PIPELINED) begin : g_pipe
    logic [DATA_W-1:0] out_q;
    logic              vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0;
        vld_q <= 1'b0;
      end else begin
        out_q <= rd_word;
        // a deselect kills the pending beat in the same clock
        vld_q <= rd_q && !ctl.desel;
      end
    end
    assign out_data = out_q;
    assign out_vld  = vld_q;
  end else begin : g_flow
    assign out_data = rd_word;
    assign out_vld  = rd_q;
  end

  assign drive_o = out_vld && !out_en_ni;
  assign data_o  = drive_o ? out_data : '0;
endmodule

// File: rtl/sync_burst_sram_checks.sv
module sync_burst_sram_checks #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cpu_strobe_ni,
  input logic              ctl_strobe_ni,
  input logic              adv_ni,
  input logic              sel_a_ni,
  input logic              sel_b_i,
  input logic              sel_c_ni,
  input logic              wr_all_ni,
  input logic [LANES-1:0]  lane_ni,
  input logic              out_en_ni,
  input logic              linear_i,
  input logic              drive_o,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we,
  input logic [LANES-1:0]  mem_mask
);
  logic sel_good, cpu_go, ctl_go;
  assign sel_good = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign cpu_go   = !cpu_strobe_ni && !sel_a_ni;
  assign ctl_go   = !ctl_strobe_ni && !cpu_go;

  p_ctl_unsel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_go && !sel_good) |=> !drive_o);

  p_cpu_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_ni && ctl_strobe_ni && adv_ni) |=>
      ($stable(cur_addr) || (linear_i != $past(linear_i))));

  p_cpu_desel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_go && !sel_good) |=> !drive_o);

  p_cpu_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_go |-> !mem_we);

  p_load_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_go || ctl_go) && sel_good) |=> (cur_addr == $past(addr_i)));

  p_suspend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_strobe_ni && cpu_strobe_ni && adv_ni) |=>
      ($stable(cur_addr) || (linear_i != $past(linear_i))));

  p_global_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !wr_all_ni) |-> (&mem_mask));

  p_lane_map_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && wr_all_ni) |-> (mem_mask == ~lane_ni));

  p_oe_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !drive_o);
endmodule

bind sync_burst_sram sync_burst_sram_checks #(.ADDR_W(ADDR_W), .LANES(LANES)) i_checks (
  .clk_i, .rst_ni, .addr_i, .cpu_strobe_ni, .ctl_strobe_ni, .adv_ni,
  .sel_a_ni, .sel_b_i, .sel_c_ni, .wr_all_ni, .lane_ni, .out_en_ni,
  .linear_i, .drive_o,
  .cur_addr (cur_addr),
  .mem_we   (mem_we),
  .mem_mask (mem_mask)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int AW = 6, LN = 8, DW = 64, DEPTH = 64;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic          cpu_n, ctl_n, adv_n, a_n, b, c_n, gw_n, bwe_n, oe_n, lin;
  logic [LN-1:0] bw_n;
  logic [DW-1:0] wdata, data_o;
  logic          drive_o;
  string         req;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .PIPELINED(1'b1)) i_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cpu_strobe_ni(cpu_n),
    .ctl_strobe_ni(ctl_n), .adv_ni(adv_n), .sel_a_ni(a_n), .sel_b_i(b),
    .sel_c_ni(c_n), .wr_all_ni(gw_n), .wr_en_ni(bwe_n), .lane_ni(bw_n),
    .out_en_ni(oe_n), .linear_i(lin), .wdata_i(wdata), .data_o(data_o),
    .drive_o(drive_o)
  );

  typedef struct {
    int            due;
    logic          drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  int            checks = 0, errors = 0, edge_n = 0;
  bit            done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_act = 1'b0, m_rd = 1'b0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] low;
    low = lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
    return {m_base[AW-1:2], low};
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
  endfunction

  task automatic idle_in();
    cpu_n = 1; ctl_n = 1; adv_n = 1; a_n = 0; b = 1; c_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0;
  endtask

  // driver: one clock, model update, expected output pushed to scoreboard
  task automatic step();
    logic cs, xs, ok, ld, ds, wr;
    logic [LN-1:0] m;
    logic [DW-1:0] rv;
    exp_t e;
    @(posedge clk);
    edge_n++;
    cs = !cpu_n && !a_n;
    xs = !ctl_n && !cs;
    ok = !a_n && b && !c_n;
    ld = (cs || xs) && ok;
    ds = (cs || xs) && !ok;
    rv = ref_mem[m_addr()];
    e.due  = edge_n;
    e.drv  = m_rd && !ds && !oe_n;
    e.data = e.drv ? rv : '0;
    e.tag  = req;
    sb_q.push_back(e);
    if (ld) begin
      m_base = addr; m_cnt = '0; m_act = 1;
    end else if (ds) begin
      m_act = 0;
    end else if (!(cs || xs) && m_act && !adv_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    m  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
    wr = m_act && (m != 0) && !cs;
    if (wr)
      for (int l = 0; l < LN; l++)
        if (m[l]) ref_mem[m_addr()][l*8 +: 8] = wdata[l*8 +: 8];
    m_rd = m_act && !wr;
    @(negedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0 && sb_q[0].due == edge_n) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (drive_o !== e.drv || data_o !== e.data) begin
        errors++;
        $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                 e.tag, drive_o, data_o, e.drv, e.data);
      end
    end
  end

  task automatic start_rd(bit via_cpu, logic [AW-1:0] a);
    idle_in();
    if (via_cpu) cpu_n = 0; else ctl_n = 0;
    addr = a;
    step();
  endtask

  task automatic burst_rd(bit via_cpu, logic [AW-1:0] a);
    start_rd(via_cpu, a);
    idle_in(); adv_n = 0;
    repeat (3) step();
    idle_in();
    repeat (2) step();
  endtask

  initial begin
    idle_in(); lin = 1; addr = '0; wdata = '0; req = "reset";
    repeat (3) @(negedge clk);
    checks++;
    if (drive_o !== 1'b0 || data_o !== '0) begin
      errors++;
      $display("FAIL R10 reset: drive=%0b data=%h expected drive=0 data=0", drive_o, data_o);
    end
    rst_n = 1;
    #1;

    req = "R5 R6 fill";
    for (int bb = 0; bb < DEPTH / 4; bb++) begin
      idle_in(); ctl_n = 0; gw_n = 0; addr = AW'(bb * 4); wdata = pat(bb * 4);
      step();
      idle_in(); gw_n = 0; adv_n = 0;
      for (int j = 1; j < 4; j++) begin
        wdata = pat(bb * 4 + j);
        step();
      end
    end
    idle_in(); step();

    req = "R11 R6 R7 linear burst";  lin = 1; burst_rd(1, 6'h09);
    req = "R7 interleaved burst";    lin = 0; idle_in(); step(); burst_rd(1, 6'h15);
    req = "R7 interleaved ctl burst"; burst_rd(0, 6'h1E);
    lin = 1; idle_in(); step();

    req = "R5 R9 partial lanes";
    idle_in(); ctl_n = 0; bwe_n = 0; bw_n = 8'b1101_1110; addr = 6'h22;
    wdata = 64'h5555_5555_5555_5555; step();
    idle_in(); step();
    burst_rd(0, 6'h22);

    req = "R4 cpu start ignores write";
    idle_in(); cpu_n = 0; gw_n = 0; addr = 6'h30; wdata = '1; step();
    idle_in(); repeat (2) step();

    req = "R12 write after cpu read";
    start_rd(1, 6'h31);
    idle_in(); bwe_n = 0; bw_n = 8'h7E; wdata = 64'hA1B2_C3D4_E5F6_0718; step();
    idle_in(); repeat (2) step();

    req = "R8 global write";
    idle_in(); ctl_n = 0; gw_n = 0; bwe_n = 0; bw_n = '1; addr = 6'h33;
    wdata = 64'hFEED_FACE_CAFE_BEEF; step();
    idle_in(); repeat (2) step();

    req = "R9 all lanes high reads";
    idle_in(); ctl_n = 0; bwe_n = 0; bw_n = '1; addr = 6'h34; wdata = '0; step();
    idle_in(); repeat (2) step();

    req = "R10 output enable";
    start_rd(0, 6'h35);
    idle_in(); oe_n = 1; step(); step();
    idle_in(); step();

    req = "R3 cpu deselect mid burst";
    start_rd(1, 6'h38);
    idle_in(); adv_n = 0; step();
    idle_in(); cpu_n = 0; b = 0; step();
    idle_in(); repeat (2) step();

    req = "R3 ctl deselect mid burst";
    start_rd(0, 6'h3C);
    idle_in(); adv_n = 0; step();
    idle_in(); ctl_n = 0; c_n = 1; step();
    idle_in(); repeat (2) step();

    req = "R2 cpu strobe ignored";
    start_rd(1, 6'h10);
    idle_in(); a_n = 1; cpu_n = 0; adv_n = 0; step(); step();
    idle_in(); a_n = 1; cpu_n = 0; step();
    idle_in(); step();

    req = "R1 unselected ctl write";
    idle_in(); ctl_n = 0; a_n = 1; gw_n = 0; addr = 6'h21; wdata = '0; step();
    idle_in(); repeat (2) step();
    burst_rd(0, 6'h21);

    req = "R6 suspend write";
    idle_in(); ctl_n = 0; gw_n = 0; addr = 6'h24; wdata = 64'h1111_2222_3333_4444; step();
    idle_in(); gw_n = 0; wdata = 64'h5555_6666_7777_8888; step();
    idle_in(); gw_n = 0; adv_n = 0; wdata = 64'h9999_AAAA_BBBB_CCCC; step();
    idle_in(); step();
    req = "R6 R11 suspend write readback"; burst_rd(1, 6'h24);

    req = "R11 drain";
    idle_in(); repeat (3) step();

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule